// File: doc/BRIEF.md
# Memory Region Predecoder

This block sits in front of the memory system and classifies each bus address by the area it falls in: ROM/Flash, RAM, boot ROM or the I/O pages. For the chosen area it raises one preselect line. It reports the data width of that area and gives the address that the area's memory should see. When ROM/Flash is relocated upward, the block subtracts the relocation base from the address, so the ROM always sees an offset from zero. Addresses outside every window raise an error strobe and select nothing.

Two request inputs change the result. A patch request arms a one-shot redirect. The next access that lands in ROM/Flash goes to the patch store instead of the ROM. A DMA request makes the block decode the DMA address in place of the CPU address. A DMA cycle moves data between memory and an I/O location, so the I/O select is raised next to the memory select. Window bases and sizes are parameters. All decoding is combinational. The only stored state is the pending patch flag.

Top module: `mrp_predecoder`

## Requirements
- R1: With the remap input low and no DMA request, an address raises exactly one select. ROM for [0x000000, 0x0C0000), boot ROM for [0x0C0000, 0x0D0000), I/O for [0x0F0000, 0x100000), RAM for [0x100000, 0x140000).
- R2: With the remap input high, the ROM window moves to [0x200000, 0x2C0000), and addresses below 0x0C0000 hit no window.
- R3: For a ROM hit with remap high, mem_addr equals the decoded address minus 0x200000. In every other case mem_addr equals the decoded address.
- R4: width_code uses 00 = 8 bit, 01 = 16 bit and 10 = 32 bit. A ROM hit copies the rom_width input and a RAM hit copies the ram_width input. A boot ROM hit gives 10 and an I/O hit gives 01. An unmapped address gives 00.
- R5: An address in no window raises map_err and leaves all selects low.
- R6: When patch_req is high at a rising clock edge, a redirect is armed. The next ROM hit then raises sel_patch in place of sel_rom.
- R7: An armed redirect is used up by exactly one ROM-hit cycle. Cycles that hit other areas leave it armed. A patch_req at the consuming edge arms it again.
- R8: While dma_req is high, the decode uses dma_addr. While it is low, the decode uses cpu_addr.
- R9: With dma_req high, a hit in ROM, RAM or boot ROM, or a patch hit, also raises sel_io. A DMA address in the I/O window raises sel_io alone.
- R10: Synchronous reset clears any armed redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Address from the processor |
| dma_addr | input | ADDR_W | Address from the DMA engine |
| dma_req | input | 1 | Current access is a DMA transfer |
| rom_remap | input | 1 | Place ROM/Flash at the upper base |
| rom_width | input | 2 | Width code for the ROM/Flash area |
| ram_width | input | 2 | Width code for the RAM area |
| patch_req | input | 1 | Arm a redirect of the next ROM access |
| sel_rom | output | 1 | ROM/Flash preselect |
| sel_ram | output | 1 | RAM preselect |
| sel_boot | output | 1 | Boot ROM preselect |
| sel_io | output | 1 | I/O page preselect |
| sel_patch | output | 1 | Patch store preselect |
| map_err | output | 1 | Address hits no window |
| width_code | output | 2 | Data width of the selected area |
| mem_addr | output | ADDR_W | Address presented to the selected memory |

## Verification
The bench builds the block with its default parameters: a 24-bit address, ROM sizes of 0xC0000 at bases 0x0 and 0x200000, and 64 KiB boot and I/O windows. The I/O window lies right below RAM, and the gap at 0x0D0000 lies between boot ROM and I/O. Because of this layout, directed addresses can probe both sides of every window edge. The defaults also put the upper ROM base inside the 24-bit range, so the subtraction can be checked at both ends of the relocated window. The same layout lets one sequence interleave RAM and I/O cycles while a patch redirect waits.

// File: rtl/mrp_pkg.sv
package mrp_pkg;

    typedef enum logic [1:0] {
        WID_8  = 2'b00,
        WID_16 = 2'b01,
        WID_32 = 2'b10
    } wid_e;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_ROM  = 3'd1,
        RG_RAM  = 3'd2,
        RG_BOOT = 3'd3,
        RG_IO   = 3'd4
    } region_e;

    // window slots checked by the matcher array
    localparam int NWIN       = 5;
    localparam int WIN_ROM_LO = 0;
    localparam int WIN_ROM_HI = 1;
    localparam int WIN_RAM    = 2;
    localparam int WIN_BOOT   = 3;
    localparam int WIN_IO     = 4;

    typedef struct packed {
        logic rom;
        logic ram;
        logic boot;
        logic io;
        logic patch;
        logic err;
    } sel_t;

    function automatic region_e slot_region(input int idx);
        case (idx)
            WIN_ROM_LO, WIN_ROM_HI: return RG_ROM;
            WIN_RAM:                return RG_RAM;
            WIN_BOOT:               return RG_BOOT;
            WIN_IO:                 return RG_IO;
            default:                return RG_NONE;
        endcase
    endfunction

    function automatic logic is_memory(input region_e r);
        return (r == RG_ROM) || (r == RG_RAM) || (r == RG_BOOT);
    endfunction

endpackage

// File: rtl/mrp_addr_mux.sv
module mrp_addr_mux #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              dma_req,
    output logic [ADDR_W-1:0] eff_addr
);
    always_comb begin
        eff_addr = dma_req ? dma_addr : cpu_addr;
    end
endmodule

// File: rtl/mrp_window_match.sv
module mrp_window_match #(
    parameter int          ADDR_W = 24,
    parameter int unsigned BASE   = 0,
    parameter int unsigned SIZE   = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              enable,
    output logic              hit
);
    localparam logic [32:0] LO = 33'(BASE);
    localparam logic [32:0] HI = 33'(BASE) + 33'(SIZE);

    logic [32:0] wide;

    always_comb begin
        wide = 33'(addr);
        hit  = enable && (wide >= LO) && (wide < HI);
    end
endmodule

// File: rtl/mrp_region_resolve.sv
module mrp_region_resolve
    import mrp_pkg::*;
#(
    parameter logic [1:0] BOOT_WID = 2'b10,
    parameter logic [1:0] IO_WID   = 2'b01
) (
    input  logic [NWIN-1:0] hits,
    input  logic [1:0]      rom_width,
    input  logic [1:0]      ram_width,
    output region_e         region,
    output logic [1:0]      width_code
);
    always_comb begin
        region = RG_NONE;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hits[i]) region = slot_region(i);
        end
        case (region)
            RG_ROM:  width_code = rom_width;
            RG_RAM:  width_code = ram_width;
            RG_BOOT: width_code = BOOT_WID;
            RG_IO:   width_code = IO_WID;
            default: width_code = WID_8;
        endcase
    end
endmodule

// File: rtl/mrp_patch_tracker.sv
module mrp_patch_tracker (
    input  logic clk,
    input  logic rst,
    input  logic patch_req,
    input  logic rom_hit,
    output logic redirect
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= patch_req | (pend_q & ~rom_hit);
    end

    always_comb begin
        redirect = pend_q & rom_hit;
    end
endmodule

// File: rtl/mrp_predecoder.sv
module mrp_predecoder
    import mrp_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter int unsigned ROM_LO_BASE = 32'h000000,
    parameter int unsigned ROM_HI_BASE = 32'h200000,
    parameter int unsigned ROM_SIZE    = 32'h0C0000,
    parameter int unsigned RAM_BASE    = 32'h100000,
    parameter int unsigned RAM_SIZE    = 32'h040000,
    parameter int unsigned BOOT_BASE   = 32'h0C0000,
    parameter int unsigned BOOT_SIZE   = 32'h010000,
    parameter int unsigned IO_BASE     = 32'h0F0000,
    parameter int unsigned IO_SIZE     = 32'h010000,
    parameter logic [1:0]  BOOT_WID    = 2'b10,
    parameter logic [1:0]  IO_WID      = 2'b01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              dma_req,
    input  logic              rom_remap,
    input  logic [1:0]        rom_width,
    input  logic [1:0]        ram_width,
    input  logic              patch_req,
    output logic              sel_rom,
    output logic              sel_ram,
    output logic              sel_boot,
    output logic              sel_io,
    output logic              sel_patch,
    output logic              map_err,
    output logic [1:0]        width_code,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int unsigned WIN_BASE [NWIN] = '{ROM_LO_BASE, ROM_HI_BASE, RAM_BASE, BOOT_BASE, IO_BASE};
    localparam int unsigned WIN_SIZE [NWIN] = '{ROM_SIZE, ROM_SIZE, RAM_SIZE, BOOT_SIZE, IO_SIZE};
    localparam logic [ADDR_W-1:0] HI_OFFSET = ADDR_W'(ROM_HI_BASE);

    logic [ADDR_W-1:0] eff_addr;
    logic [NWIN-1:0]   win_en;
    logic [NWIN-1:0]   hits;
    region_e           region;
    logic              rom_hit;
    logic              redirect;
    sel_t              sel;

    mrp_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
        .cpu_addr (cpu_addr),
        .dma_addr (dma_addr),
        .dma_req  (dma_req),
        .eff_addr (eff_addr)
    );

    always_comb begin
        win_en             = '1;
        win_en[WIN_ROM_LO] = ~rom_remap;
        win_en[WIN_ROM_HI] = rom_remap;
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        mrp_window_match #(
            .ADDR_W (ADDR_W),
            .BASE   (WIN_BASE[g]),
            .SIZE   (WIN_SIZE[g])
        ) u_match (
            .addr   (eff_addr),
            .enable (win_en[g]),
            .hit    (hits[g])
        );
    end

    mrp_region_resolve #(
        .BOOT_WID (BOOT_WID),
        .IO_WID   (IO_WID)
    ) u_resolve (
        .hits       (hits),
        .rom_width  (rom_width),
        .ram_width  (ram_width),
        .region     (region),
        .width_code (width_code)
    );

    assign rom_hit = (region == RG_ROM);

    mrp_patch_tracker u_patch (
        .clk       (clk),
        .rst       (rst),
        .patch_req (patch_req),
        .rom_hit   (rom_hit),
        .redirect  (redirect)
    );

    always_comb begin
        sel       = '0;
        sel.rom   = rom_hit & ~redirect;
        sel.patch = redirect;
        sel.ram   = (region == RG_RAM);
        sel.boot  = (region == RG_BOOT);
        sel.io    = (region == RG_IO) | (dma_req & is_memory(region));
        sel.err   = (region == RG_NONE);
    end

    always_comb begin
        if (rom_hit && rom_remap) mem_addr = eff_addr - HI_OFFSET;
        else                      mem_addr = eff_addr;
    end

    assign sel_rom   = sel.rom;
    assign sel_ram   = sel.ram;
    assign sel_boot  = sel.boot;
    assign sel_io    = sel.io;
    assign sel_patch = sel.patch;
    assign map_err   = sel.err;
endmodule

// File: rtl/mrp_predecoder_chk.sv
module mrp_predecoder_chk #(
    parameter int          ADDR_W   = 24,
    parameter int unsigned ROM_SIZE = 32'h0C0000
) (
    input logic              clk,
    input logic              rst,
    input logic              dma_req,
    input logic              patch_req,
    input logic              sel_rom,
    input logic              sel_ram,
    input logic              sel_boot,
    input logic              sel_io,
    input logic              sel_patch,
    input logic              map_err,
    input logic [ADDR_W-1:0] mem_addr
);
    // R1
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        !dma_req |-> $onehot0({sel_rom, sel_ram, sel_boot, sel_io, sel_patch}));

    // R5
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        map_err |-> !(sel_rom || sel_ram || sel_boot || sel_io || sel_patch));

    // R3
    rom_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_rom || sel_patch) |-> (33'(mem_addr) < 33'(ROM_SIZE)));

    // R6
    patch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sel_rom && sel_patch));

    // R7
    patch_once_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_patch && !patch_req) |=> !sel_patch);

    // R9
    dma_dual_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_req && (sel_rom || sel_ram || sel_boot || sel_patch)) |-> sel_io);
endmodule

bind mrp_predecoder mrp_predecoder_chk #(
    .ADDR_W   (ADDR_W),
    .ROM_SIZE (ROM_SIZE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dma_req   (dma_req),
    .patch_req (patch_req),
    .sel_rom   (sel_rom),
    .sel_ram   (sel_ram),
    .sel_boot  (sel_boot),
    .sel_io    (sel_io),
    .sel_patch (sel_patch),
    .map_err   (map_err),
    .mem_addr  (mem_addr)
);

// File: tb/sim_mrp_predecoder.sv
module sim_mrp_predecoder;
    localparam int AW = 24;
    localparam logic [5:0] S_ROM = 6'b100000;
    localparam logic [5:0] S_RAM = 6'b010000;
    localparam logic [5:0] S_BOOT = 6'b001000;
    localparam logic [5:0] S_IO = 6'b000100;
    localparam logic [5:0] S_PAT = 6'b000010;
    localparam logic [5:0] S_ERR = 6'b000001;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cpu_addr = '0;
    logic [AW-1:0] dma_addr = '0;
    logic          dma_req = 1'b0;
    logic          rom_remap = 1'b0;
    logic [1:0]    rom_width = 2'b00;
    logic [1:0]    ram_width = 2'b00;
    logic          patch_req = 1'b0;
    logic sel_rom, sel_ram, sel_boot, sel_io, sel_patch, map_err;
    logic [1:0]    width_code;
    logic [AW-1:0] mem_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mrp_predecoder u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .dma_addr(dma_addr),
        .dma_req(dma_req), .rom_remap(rom_remap), .rom_width(rom_width),
        .ram_width(ram_width), .patch_req(patch_req), .sel_rom(sel_rom),
        .sel_ram(sel_ram), .sel_boot(sel_boot), .sel_io(sel_io),
        .sel_patch(sel_patch), .map_err(map_err), .width_code(width_code),
        .mem_addr(mem_addr)
    );

    function automatic logic [5:0] sels();
        return {sel_rom, sel_ram, sel_boot, sel_io, sel_patch, map_err};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at the falling edge, sample 1 ns later
    task automatic put(input logic [AW-1:0] a);
        @(negedge clk);
        cpu_addr = a;
        #1;
    endtask

    task automatic t_reset();
        patch_req = 1'b1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        patch_req = 1'b0;
        rst = 1'b0;
        put(24'h000010);
        chk("R10 reset no redirect", 32'(sels()), 32'(S_ROM));
        chk("R3 plain addr", 32'(mem_addr), 32'h10);
    endtask

    task automatic t_plain();
        rom_remap = 1'b0;
        put(24'h000000); chk("R1 rom low", 32'(sels()), 32'(S_ROM));
        put(24'h0BFFFF); chk("R1 rom top", 32'(sels()), 32'(S_ROM));
        put(24'h0C0000); chk("R1 boot low", 32'(sels()), 32'(S_BOOT));
        put(24'h0CFFFF); chk("R1 boot top", 32'(sels()), 32'(S_BOOT));
        put(24'h0D0000); chk("R5 gap", 32'(sels()), 32'(S_ERR));
        put(24'h0F0000); chk("R1 io low", 32'(sels()), 32'(S_IO));
        put(24'h0FFFFF); chk("R1 io top", 32'(sels()), 32'(S_IO));
        put(24'h100000); chk("R1 ram low", 32'(sels()), 32'(S_RAM));
        put(24'h13FFFF); chk("R1 ram top", 32'(sels()), 32'(S_RAM));
        put(24'h140000); chk("R5 above ram", 32'(sels()), 32'(S_ERR));
        put(24'h200000); chk("R2 upper rom off", 32'(sels()), 32'(S_ERR));
    endtask

    task automatic t_remap();
        rom_remap = 1'b1;
        put(24'h200000); chk("R2 hi rom low", 32'(sels()), 32'(S_ROM));
        chk("R3 offset low", 32'(mem_addr), 32'h0);
        put(24'h2BFFFF); chk("R2 hi rom top", 32'(sels()), 32'(S_ROM));
        chk("R3 offset top", 32'(mem_addr), 32'h0BFFFF);
        put(24'h2C0000); chk("R2 past hi rom", 32'(sels()), 32'(S_ERR));
        put(24'h000010); chk("R2 low rom gone", 32'(sels()), 32'(S_ERR));
        chk("R3 err passthru", 32'(mem_addr), 32'h10);
        put(24'h100004); chk("R1 ram remapped", 32'(sels()), 32'(S_RAM));
        chk("R3 ram passthru", 32'(mem_addr), 32'h100004);
        rom_remap = 1'b0;
    endtask

    task automatic t_width();
        rom_width = 2'b00; ram_width = 2'b01;
        put(24'h000100); chk("R4 rom 8", 32'(width_code), 32'h0);
        @(negedge clk); rom_width = 2'b10; #1;
        chk("R4 rom 32", 32'(width_code), 32'h2);
        put(24'h100100); chk("R4 ram 16", 32'(width_code), 32'h1);
        put(24'h0C0100); chk("R4 boot 32", 32'(width_code), 32'h2);
        put(24'h0F0100); chk("R4 io 16", 32'(width_code), 32'h1);
        put(24'h0E0000); chk("R4 err 00", 32'(width_code), 32'h0);
    endtask

    task automatic t_dma();
        @(negedge clk);
        cpu_addr = 24'h100000; dma_addr = 24'h000020; dma_req = 1'b1; #1;
        chk("R9 dma rom+io", 32'(sels()), 32'(S_ROM | S_IO));
        chk("R8 dma addr used", 32'(mem_addr), 32'h20);
        @(negedge clk); dma_addr = 24'h100040; #1;
        chk("R9 dma ram+io", 32'(sels()), 32'(S_RAM | S_IO));
        @(negedge clk); dma_addr = 24'h0C0040; #1;
        chk("R9 dma boot+io", 32'(sels()), 32'(S_BOOT | S_IO));
        @(negedge clk); dma_addr = 24'h0F0010; #1;
        chk("R9 dma io only", 32'(sels()), 32'(S_IO));
        @(negedge clk); dma_addr = 24'h0E0000; #1;
        chk("R9 dma unmapped", 32'(sels()), 32'(S_ERR));
        @(negedge clk); dma_req = 1'b0; #1;
        chk("R8 cpu addr back", 32'(sels()), 32'(S_RAM));
        chk("R8 cpu mem_addr", 32'(mem_addr), 32'h100000);
    endtask

    task automatic t_patch();
        @(negedge clk); patch_req = 1'b1; cpu_addr = 24'h100000; #1;
        chk("R6 ram while arming", 32'(sels()), 32'(S_RAM));
        @(negedge clk); patch_req = 1'b0; cpu_addr = 24'h0F0000; #1;
        chk("R7 io keeps armed", 32'(sels()), 32'(S_IO));
        put(24'h000040); chk("R6 redirect", 32'(sels()), 32'(S_PAT));
        chk("R6 redirect addr", 32'(mem_addr), 32'h40);
        put(24'h000044); chk("R7 used up", 32'(sels()), 32'(S_ROM));
        // same-cycle arm and rearm at consuming edge
        @(negedge clk); patch_req = 1'b1; cpu_addr = 24'h000048; #1;
        chk("R6 not same cycle", 32'(sels()), 32'(S_ROM));
        @(negedge clk); #1;
        chk("R7 rearm consume 1", 32'(sels()), 32'(S_PAT));
        @(negedge clk); patch_req = 1'b0; #1;
        chk("R7 rearm consume 2", 32'(sels()), 32'(S_PAT));
        @(negedge clk); #1;
        chk("R7 cleared", 32'(sels()), 32'(S_ROM));
        // patch during DMA keeps io
        @(negedge clk); patch_req = 1'b1; #1;
        @(negedge clk); patch_req = 1'b0; dma_req = 1'b1; dma_addr = 24'h000080; #1;
        chk("R9 dma patch+io", 32'(sels()), 32'(S_PAT | S_IO));
        @(negedge clk); dma_req = 1'b0; #1;
    endtask

    initial begin
        t_reset();
        t_plain();
        t_remap();
        t_width();
        t_dma();
        t_patch();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule